// File: doc/BRIEF.md
# SD Host Interrupt Status Register Bank

This block keeps the event-status word of an SD host controller together with two per-bit masks: one that decides which events may be recorded, and one that decides which recorded events may raise the interrupt line. The command and data engines report events as single-cycle pulses on a 32-bit event vector. A pulse sets its sticky status bit only when the matching record-enable bit is set. Software clears status bits by writing ones to them.

The interrupt line is high while any recorded bit is also enabled for signalling. The line is registered, so it follows the status and the signal mask one cycle late. Two combinational summary outputs group the command-path faults and the data-path faults. Driver code can then check a single wire after a command or a transfer.

Register access uses a select code, a write strobe, write data and a combinational read-data port. Reads have no side effects.

Top module: `isr_bank`

## Requirements
- R1: After reset the status register, the record-enable mask and the signal-enable mask all read zero, and `irq_o`, `cmd_err_o` and `dat_err_o` are low.
- R2: A pulse on `evt_i[n]`, with record-enable bit n set, makes status bit n read as one in the cycle after the pulse. The bit then stays set until it is cleared.
- R3: A pulse on `evt_i[n]` while record-enable bit n is clear leaves status bit n unchanged. Suppressing buffer-read-ready (bit 5) and buffer-write-ready (bit 4) is one use of this.
- R4: A write with `acc_sel`=0 clears each status bit whose write-data bit is one and leaves every other bit unchanged. Writing all ones clears the whole register.
- R5: If a pulse on an enabled event arrives in the same cycle as a clear of that bit, the bit stays set.
- R6: Only bits 0–8, 16–22, 24 and 28 are implemented. In all three registers every other position reads zero, ignores writes and ignores event pulses.
- R7: `irq_o` equals the OR over all bits of (status AND signal-enable), taken one clock earlier.
- R8: `cmd_err_o` is high exactly when status bit 17 (command CRC), bit 18 (command end-bit) or bit 19 (command index) is set. Command timeout (bit 16) does not drive it.
- R9: `dat_err_o` is high exactly when status bit 20 (data timeout), bit 21 (data CRC) or bit 22 (data end-bit) is set. Auto-CMD12 error (bit 24) and DMA error (bit 28) do not drive it.
- R10: `acc_sel`=1 selects the record-enable mask and `acc_sel`=2 selects the signal-enable mask. A write stores the data, and the selected register reads it back in the next cycle. `acc_sel`=0 reads the status register and `acc_sel`=3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Single-cycle event pulses, one per status position |
| acc_we | input | 1 | Register write strobe |
| acc_sel | input | 2 | Register select: 0 status, 1 record-enable, 2 signal-enable, 3 none |
| acc_wdata | input | 32 | Write data (ones clear status bits when acc_sel=0) |
| acc_rdata | output | 32 | Combinational read data of the selected register |
| irq_o | output | 1 | Registered level interrupt |
| cmd_err_o | output | 1 | Command fault summary |
| dat_err_o | output | 1 | Data fault summary |

## Verification
Assertions watch the following on every cycle:
- an enabled pulse always lands in the status register, including when a clear hits the same bit;
- no status bit rises without an enabled pulse;
- a cleared bit with no competing pulse drops;
- reserved read positions stay zero;
- the interrupt line tracks the masked status one cycle late;
- each summary output rises only after an enabled fault pulse of its own group.

The bench's scenarios cover the rest. These include that a clear with zeros leaves bits alone, that masked events leave no trace, that mask writes read back exactly, and that timeout and auto-CMD12 faults stay out of the wrong summary. Long random runs of interleaved pulses, clears and mask changes are checked against a bench model of the full register state.

// File: rtl/isr_pkg.sv
package isr_pkg;

   // Status positions used by the summaries and named in the notes
   localparam int unsigned BIT_CMD_DONE  = 0;
   localparam int unsigned BIT_XFER_DONE = 1;
   localparam int unsigned BIT_BUF_WR    = 4;
   localparam int unsigned BIT_BUF_RD    = 5;
   localparam int unsigned BIT_CMD_TMO   = 16;
   localparam int unsigned BIT_CMD_CRC   = 17;
   localparam int unsigned BIT_CMD_END   = 18;
   localparam int unsigned BIT_CMD_IDX   = 19;
   localparam int unsigned BIT_DAT_TMO   = 20;
   localparam int unsigned BIT_DAT_CRC   = 21;
   localparam int unsigned BIT_DAT_END   = 22;
   localparam int unsigned BIT_ACMD_ERR  = 24;
   localparam int unsigned BIT_DMA_ERR   = 28;

   // Implemented positions: 0..8, 16..22, 24, 28
   localparam logic [31:0] IMPL_DEFAULT    = 32'h117F_01FF;
   localparam logic [31:0] CMD_ERR_DEFAULT = (32'd1 << BIT_CMD_CRC) |
                                             (32'd1 << BIT_CMD_END) |
                                             (32'd1 << BIT_CMD_IDX);
   localparam logic [31:0] DAT_ERR_DEFAULT = (32'd1 << BIT_DAT_TMO) |
                                             (32'd1 << BIT_DAT_CRC) |
                                             (32'd1 << BIT_DAT_END);

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_REC_EN = 2'd1,
      SEL_SIG_EN = 2'd2,
      SEL_NONE   = 2'd3
   } isr_sel_e;

endpackage

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
   parameter int unsigned      WIDTH     = 32,
   parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] mask_q;

   // Plain mask register; unimplemented positions are held at zero
   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else if (we_i)
         mask_q <= wdata_i & IMPL_MASK;
   end

   assign q_o = mask_q;

   // R10: a write is visible exactly one cycle later
   a_r10_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (q_o == ($past(wdata_i) & IMPL_MASK)));

endmodule

// File: rtl/isr_status_core.sv
module isr_status_core #(
   parameter int unsigned      WIDTH     = 32,
   parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt_i,
   input  logic [WIDTH-1:0] rec_en_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] status_o
);

   logic [WIDTH-1:0] status_q;
   logic [WIDTH-1:0] set_vec;
   logic [WIDTH-1:0] keep_vec;
   logic [WIDTH-1:0] status_d;

   // Set terms override clear terms: a fresh event is never lost
   always_comb begin
      set_vec  = evt_i & rec_en_i;
      keep_vec = status_q & ~clr_i;
      status_d = (keep_vec | set_vec) & IMPL_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         status_q <= '0;
      else
         status_q <= status_d;
   end

   assign status_o = status_q;

   // R2: an enabled pulse is recorded in the next cycle
   a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & rec_en_i & IMPL_MASK)) |=>
         ((status_q & $past(evt_i & rec_en_i & IMPL_MASK)) ==
          $past(evt_i & rec_en_i & IMPL_MASK)));

   // R5: pulse and clear on the same bit leave the bit set
   a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & rec_en_i & clr_i & IMPL_MASK)) |=>
         ((status_q & $past(evt_i & rec_en_i & clr_i & IMPL_MASK)) ==
          $past(evt_i & rec_en_i & clr_i & IMPL_MASK)));

   // R3: no bit rises without an enabled pulse
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q) & ~$past(evt_i & rec_en_i)) == '0));

   // R4: a cleared bit with no competing pulse drops
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~(evt_i & rec_en_i) & status_q)) |=>
         ((status_q & $past(clr_i & ~(evt_i & rec_en_i))) == '0));

endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
   parameter int unsigned WIDTH   = 32,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] status_i,
   input  logic [WIDTH-1:0] sig_en_i,
   output logic             irq_o
);

   logic irq_any;

   assign irq_any = |(status_i & sig_en_i);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= irq_any;
         end
         assign irq_o = irq_q;

         // R7: the line follows the masked status one cycle late
         a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o == $past(|(status_i & sig_en_i)));
      end else begin : g_comb
         assign irq_o = irq_any;
      end
   endgenerate

endmodule

// File: rtl/isr_group_or.sv
module isr_group_or #(
   parameter int unsigned      WIDTH      = 32,
   parameter logic [WIDTH-1:0] GROUP_MASK = '0
) (
   input  logic [WIDTH-1:0] status_i,
   output logic             hit_o
);

   assign hit_o = |(status_i & GROUP_MASK);

endmodule

// File: rtl/isr_bank.sv
module isr_bank
   import isr_pkg::*;
#(
   parameter int unsigned      WIDTH        = 32,
   parameter logic [WIDTH-1:0] IMPL_MASK    = IMPL_DEFAULT[WIDTH-1:0],
   parameter logic [WIDTH-1:0] CMD_ERR_MASK = CMD_ERR_DEFAULT[WIDTH-1:0],
   parameter logic [WIDTH-1:0] DAT_ERR_MASK = DAT_ERR_DEFAULT[WIDTH-1:0],
   parameter bit               IRQ_REG      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt_i,
   input  logic             acc_we,
   input  logic [1:0]       acc_sel,
   input  logic [WIDTH-1:0] acc_wdata,
   output logic [WIDTH-1:0] acc_rdata,
   output logic             irq_o,
   output logic             cmd_err_o,
   output logic             dat_err_o
);

   // Elaboration checks on the parameter set
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("isr_bank: WIDTH must be positive");
      end
      if ((CMD_ERR_MASK & ~IMPL_MASK) != '0) begin : g_bad_cmd
         $error("isr_bank: command fault group uses unimplemented bits");
      end
      if ((DAT_ERR_MASK & ~IMPL_MASK) != '0) begin : g_bad_dat
         $error("isr_bank: data fault group uses unimplemented bits");
      end
      if ((CMD_ERR_MASK & DAT_ERR_MASK) != '0) begin : g_bad_overlap
         $error("isr_bank: fault groups overlap");
      end
   endgenerate

   isr_sel_e         sel;
   logic             we_status;
   logic             we_rec;
   logic             we_sig;
   logic [WIDTH-1:0] clr_vec;
   logic [WIDTH-1:0] rec_en_q;
   logic [WIDTH-1:0] sig_en_q;
   logic [WIDTH-1:0] status_q;

   assign sel       = isr_sel_e'(acc_sel);
   assign we_status = acc_we && (sel == SEL_STATUS);
   assign we_rec    = acc_we && (sel == SEL_REC_EN);
   assign we_sig    = acc_we && (sel == SEL_SIG_EN);
   assign clr_vec   = we_status ? acc_wdata : '0;

   isr_mask_reg #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_rec_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we_rec),
      .wdata_i (acc_wdata),
      .q_o     (rec_en_q)
   );

   isr_mask_reg #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_sig_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we_sig),
      .wdata_i (acc_wdata),
      .q_o     (sig_en_q)
   );

   isr_status_core #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .rec_en_i (rec_en_q),
      .clr_i    (clr_vec),
      .status_o (status_q)
   );

   isr_irq_gen #(.WIDTH(WIDTH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .sig_en_i (sig_en_q),
      .irq_o    (irq_o)
   );

   isr_group_or #(.WIDTH(WIDTH), .GROUP_MASK(CMD_ERR_MASK)) u_cmd_sum (
      .status_i (status_q),
      .hit_o    (cmd_err_o)
   );

   isr_group_or #(.WIDTH(WIDTH), .GROUP_MASK(DAT_ERR_MASK)) u_dat_sum (
      .status_i (status_q),
      .hit_o    (dat_err_o)
   );

   // Read port: side-effect free
   always_comb begin
      unique case (sel)
         SEL_STATUS: acc_rdata = status_q;
         SEL_REC_EN: acc_rdata = rec_en_q;
         SEL_SIG_EN: acc_rdata = sig_en_q;
         default:    acc_rdata = '0;
      endcase
   end

   // R6: unimplemented positions never show up on the read port
   a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_rdata & ~IMPL_MASK) == '0));

   // R8: command summary rises only after an enabled command fault pulse
   a_r8_cmd_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err_o) |-> $past(|(evt_i & rec_en_q & CMD_ERR_MASK)));

   // R9: data summary rises only after an enabled data fault pulse
   a_r9_dat_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_err_o) |-> $past(|(evt_i & rec_en_q & DAT_ERR_MASK)));

endmodule

// File: tb/isr_bank_bench.sv
`timescale 1ns/1ps
module isr_bank_bench;

   localparam logic [31:0] M_IMPL = 32'h117F_01FF;
   localparam logic [31:0] M_CMD  = 32'h000E_0000;
   localparam logic [31:0] M_DAT  = 32'h0070_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_i = '0;
   logic        acc_we = 1'b0;
   logic [1:0]  acc_sel = 2'd0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        irq_o, cmd_err_o, dat_err_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model
   logic [31:0] m_st = '0, m_rec = '0, m_sig = '0;
   logic        m_irq = 1'b0;

   always #4 clk = ~clk;

   isr_bank u_isr_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .acc_we(acc_we),
      .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .irq_o(irq_o), .cmd_err_o(cmd_err_o), .dat_err_o(dat_err_o)
   );

   function automatic logic [31:0] f_next_st(logic [31:0] st, logic [31:0] rec,
                                             logic [31:0] evt, logic [31:0] clr);
      return ((st & ~clr) | (evt & rec)) & M_IMPL;
   endfunction

   function automatic logic [31:0] f_read(logic [1:0] s);
      case (s)
         2'd0:    return m_st;
         2'd1:    return m_rec;
         2'd2:    return m_sig;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, model at posedge, compare at next negedge
   task automatic step(logic [31:0] evt, logic we, logic [1:0] sel, logic [31:0] wd,
                       string req);
      logic [31:0] clr;
      evt_i = evt; acc_we = we; acc_sel = sel; acc_wdata = wd;
      @(posedge clk);
      clr   = (we && sel == 2'd0) ? wd : 32'h0;
      m_irq = |(m_st & m_sig);
      m_st  = f_next_st(m_st, m_rec, evt, clr);
      if (we && sel == 2'd1) m_rec = wd & M_IMPL;
      if (we && sel == 2'd2) m_sig = wd & M_IMPL;
      @(negedge clk);
      chk({req, " rdata"}, acc_rdata, f_read(sel));
      chk({req, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
      chk({req, " cmd_err"}, {31'b0, cmd_err_o}, {31'b0, |(m_st & M_CMD)});
      chk({req, " dat_err"}, {31'b0, dat_err_o}, {31'b0, |(m_st & M_DAT)});
      evt_i = '0; acc_we = 1'b0;
   endtask

   task automatic idle(logic [1:0] sel, string req);
      step(32'h0, 1'b0, sel, 32'h0, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of all three registers and outputs
      for (int s = 0; s < 3; s++) idle(2'(s), "R1");
      chk("R1 irq_o", {31'b0, irq_o}, 32'h0);

      // R10 / R6: mask writes read back, reserved bits dropped
      step(32'h0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R10 rec write");
      idle(2'd1, "R10 rec read");
      chk("R6 rec reserved", acc_rdata, M_IMPL);
      step(32'h0, 1'b1, 2'd2, 32'hA5A5_5A5A, "R10 sig write");
      idle(2'd2, "R10 sig read");
      step(32'h0, 1'b1, 2'd2, 32'h0, "R10 sig zero");
      idle(2'd3, "R10 sel3 zero");
      chk("R10 sel3", acc_rdata, 32'h0);

      // R2: enabled pulse latches and sticks; no irq with signal mask zero
      step(32'h1, 1'b0, 2'd0, 32'h0, "R2 pulse");
      chk("R2 bit0", acc_rdata & 32'h1, 32'h1);
      idle(2'd0, "R2 sticky");
      chk("R7 masked irq", {31'b0, irq_o}, 32'h0);

      // R3: buffer ready bits suppressed by record mask
      step(32'h0, 1'b1, 2'd1, M_IMPL & ~32'h30, "R3 mask bufs");
      step(32'h30, 1'b0, 2'd0, 32'h0, "R3 pulse");
      chk("R3 bufs absent", acc_rdata & 32'h30, 32'h0);

      // R4: zero write keeps, one write clears
      step(32'h0, 1'b1, 2'd0, 32'h0, "R4 zero write");
      chk("R4 kept", acc_rdata & 32'h1, 32'h1);
      step(32'h0, 1'b1, 2'd0, 32'h1, "R4 clear");
      chk("R4 cleared", acc_rdata, 32'h0);

      // R5: event beats same-cycle clear
      step(32'h2, 1'b0, 2'd0, 32'h0, "R5 set");
      step(32'h2, 1'b1, 2'd0, 32'h2, "R5 race");
      chk("R5 stays", acc_rdata & 32'h2, 32'h2);

      // R7: interrupt one cycle after signal mask enables the bit
      step(32'h0, 1'b1, 2'd2, 32'h2, "R7 enable");
      chk("R7 not yet", {31'b0, irq_o}, 32'h0);
      idle(2'd0, "R7 next");
      chk("R7 high", {31'b0, irq_o}, 32'h1);
      step(32'h0, 1'b1, 2'd2, 32'h0, "R7 disable");
      chk("R7 still high", {31'b0, irq_o}, 32'h1);
      idle(2'd0, "R7 drop");
      chk("R7 low", {31'b0, irq_o}, 32'h0);
      chk("R7 status kept", acc_rdata & 32'h2, 32'h2);

      // R8: timeout does not drive command summary; end-bit does
      step(32'h0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R4 clear all");
      chk("R4 all clear", acc_rdata, 32'h0);
      step(32'h0001_0000, 1'b0, 2'd0, 32'h0, "R8 timeout");
      chk("R8 tmo no sum", {31'b0, cmd_err_o}, 32'h0);
      step(32'h0004_0000, 1'b0, 2'd0, 32'h0, "R8 endbit");
      chk("R8 endbit sum", {31'b0, cmd_err_o}, 32'h1);

      // R9: auto-cmd12 and DMA faults stay out; data CRC drives it
      step(32'h1100_0000, 1'b0, 2'd0, 32'h0, "R9 acmd dma");
      chk("R9 no sum", {31'b0, dat_err_o}, 32'h0);
      step(32'h0020_0000, 1'b0, 2'd0, 32'h0, "R9 crc");
      chk("R9 crc sum", {31'b0, dat_err_o}, 32'h1);

      // R6: all pulses with full mask only reach implemented bits
      step(32'h0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R6 rec all");
      step(32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0, "R6 all pulses");
      chk("R6 status", acc_rdata, M_IMPL);
      step(32'h0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R4 clear all 2");
      chk("R4 all clear 2", acc_rdata, 32'h0);

      // Random mix against the model (R2 R3 R4 R5 R7 R8 R9 R10)
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] e, wd;
         logic        we;
         logic [1:0]  s;
         e  = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
         we = ($urandom % 4 == 0);
         s  = 2'($urandom % 4);
         wd = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
         step(e, we, s, wd, "R2R4R5R7 random");
      end

      finish_run();
   end

endmodule